// File: doc/BRIEF.md
# Memory-to-Stream FIFO Reader

This block is the drain side of a FIFO whose storage is a circular region of an external memory. It asks a separate occupancy controller how many words the region holds and where the next one lives. Whenever enough words are present, it sends a read command to the memory. It then collects the returned word and delivers it on a valid/ready output stream.

The memory answers with a latency that varies from read to read, but always in command order. The block therefore keeps a small in-order response buffer. Before it sends a read, it reserves a slot in that buffer, so a word that comes back always has a place to land. Each read it sends is reported to the controller with a one-cycle strobe. The controller uses that strobe to lower its level and to step its read address, which wraps at the end of the region.

The threshold is programmable. Draining holds off until the level exceeds it, so a consumer can wait for a batch to accumulate before the first word moves.

Top module: `mem_stream_reader`

## Requirements
- R1: After reset, with the controller level at zero, no read command, no output word and no strobe are presented, and the return channel is not ready.
- R2: Every read command carries the controller's current read address with the write-enable field at 0, so output word i equals the memory word at region start + (i mod region size).
- R3: A read command is presented only while the controller level is strictly greater than the read threshold. When the level equals the threshold, output stays stalled indefinitely.
- R4: The controller strobe is high for exactly the cycles in which a read command is accepted (valid and ready both high), one pulse per read.
- R5: While the output is valid and not accepted, it stays valid and its data does not change in the next cycle.
- R6: The number of reads that have been accepted but not yet delivered on the output never exceeds MAX_OUT.
- R7: The return channel is ready exactly when at least one accepted read has not had its data returned. No returned word is dropped.
- R8: Under varying memory latency and output backpressure, output words appear in the order their read commands were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_thresh | input | LW | Level that must be exceeded before reading |
| ctl_level | input | LW | Words currently held in the memory region |
| ctl_rd_addr | input | AW | Address of the next word to read |
| ctl_rd_strobe | output | 1 | One pulse per accepted read command |
| mem_cmd_valid | output | 1 | Read command request |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_we | output | 1 | Write enable, always 0 |
| mem_cmd_addr | output | AW | Command address |
| mem_rdata_valid | input | 1 | Returned word present |
| mem_rdata_ready | output | 1 | Block accepts a returned word |
| mem_rdata | input | DW | Returned word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | DW | Output word |

## Verification
Four properties are checked on every cycle. A strobe is never issued at or below the threshold. A stalled output holds its word. Reads in flight never exceed the buffer size. The return channel is ready only when a read is awaiting its data.

Some behaviour shows only across a whole run, so the bench's scenarios cover it. These are the address wrap, and the exact word order under varying latency and backpressure. Two more are the indefinite stall when the level equals the threshold, and the final level settling at the threshold. Each scenario combines a different threshold with a different consumer stall pattern.

// File: rtl/mem_stream_reader.sv
module mem_stream_reader #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int LW      = 8,
  parameter int MAX_OUT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_rd_thresh,
  input  logic [LW-1:0] ctl_level,
  input  logic [AW-1:0] ctl_rd_addr,
  output logic          ctl_rd_strobe,
  output logic          mem_cmd_valid,
  input  logic          mem_cmd_ready,
  output logic          mem_cmd_we,
  output logic [AW-1:0] mem_cmd_addr,
  input  logic          mem_rdata_valid,
  output logic          mem_rdata_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int CW = $clog2(MAX_OUT + 1);
  localparam int PW = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1;

  logic [DW-1:0] slots [MAX_OUT];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] resv, fill;
  logic          issue, take, pop;

  assign mem_cmd_valid   = (ctl_level > cfg_rd_thresh) && (resv < CW'(MAX_OUT));
  assign mem_cmd_we      = 1'b0;
  assign mem_cmd_addr    = ctl_rd_addr;
  assign issue           = mem_cmd_valid && mem_cmd_ready;
  assign ctl_rd_strobe   = issue;
  assign mem_rdata_ready = resv != fill;
  assign take            = mem_rdata_valid && mem_rdata_ready;
  assign out_valid       = fill != '0;
  assign out_data        = slots[rd_ptr];
  assign pop             = out_valid && out_ready;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(MAX_OUT - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv   <= '0;
      fill   <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      resv <= resv + CW'(issue) - CW'(pop);
      fill <= fill + CW'(take) - CW'(pop);
      if (take) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
    end
  end

  always_ff @(posedge clk)
    if (take) slots[wr_ptr] <= mem_rdata;
endmodule

module mem_stream_reader_chk #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int LW      = 8,
  parameter int MAX_OUT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] cfg_rd_thresh,
  input logic [LW-1:0] ctl_level,
  input logic          ctl_rd_strobe,
  input logic          mem_cmd_valid,
  input logic          mem_cmd_ready,
  input logic          mem_rdata_valid,
  input logic          mem_rdata_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  localparam int KW = $clog2(MAX_OUT + 2) + 1;
  logic [KW-1:0] inflight, awaiting;
  logic acc, ret, dlv;

  assign acc = mem_cmd_valid && mem_cmd_ready;
  assign ret = mem_rdata_valid && mem_rdata_ready;
  assign dlv = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight <= '0;
      awaiting <= '0;
    end else begin
      inflight <= inflight + KW'(acc) - KW'(dlv);
      awaiting <= awaiting + KW'(acc) - KW'(ret);
    end
  end

  // R3
  strobe_above_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd_strobe |-> ctl_level > cfg_rd_thresh);
  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R6
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= KW'(MAX_OUT));
  // R7
  rdata_ready_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rdata_ready |-> awaiting != '0);
endmodule

bind mem_stream_reader mem_stream_reader_chk #(
  .AW(AW), .DW(DW), .LW(LW), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rd_thresh(cfg_rd_thresh), .ctl_level(ctl_level),
  .ctl_rd_strobe(ctl_rd_strobe), .mem_cmd_valid(mem_cmd_valid),
  .mem_cmd_ready(mem_cmd_ready), .mem_rdata_valid(mem_rdata_valid),
  .mem_rdata_ready(mem_rdata_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/mem_stream_reader_bench.sv
module mem_stream_reader_bench;
  localparam int AW = 8, DW = 16, LW = 8, MAX_OUT = 4;
  localparam int BASE = 8, DEPTH = 12;

  logic clk = 0, rst_n = 0;
  logic [LW-1:0] cfg_rd_thresh = '0, ctl_level = '0;
  logic [AW-1:0] ctl_rd_addr = '0, mem_cmd_addr;
  logic ctl_rd_strobe, mem_cmd_valid, mem_cmd_ready = 0, mem_cmd_we;
  logic mem_rdata_valid = 0, mem_rdata_ready, out_valid, out_ready = 0;
  logic [DW-1:0] mem_rdata = '0, out_data;

  always #4 clk = ~clk;

  mem_stream_reader #(.AW(AW), .DW(DW), .LW(LW), .MAX_OUT(MAX_OUT)) u_mem_stream_reader (
    .clk(clk), .rst_n(rst_n), .cfg_rd_thresh(cfg_rd_thresh), .ctl_level(ctl_level),
    .ctl_rd_addr(ctl_rd_addr), .ctl_rd_strobe(ctl_rd_strobe),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready), .mem_cmd_we(mem_cmd_we),
    .mem_cmd_addr(mem_cmd_addr), .mem_rdata_valid(mem_rdata_valid),
    .mem_rdata_ready(mem_rdata_ready), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  int checks = 0, failures = 0;
  int level, ridx, thr, cyc, rmode, written;
  int qaddr [64];
  int qtime [64];
  int qhead, qtail, issued, returned, popped, strobes;
  bit hold_pend;
  logic [DW-1:0] held;

  function automatic logic [DW-1:0] word_at(input int a);
    return DW'(a * 37 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit wr);
    bit fire, take, pop;
    int t;
    @(negedge clk);
    ctl_level     = LW'(level);
    ctl_rd_addr   = AW'(BASE + ridx);
    cfg_rd_thresh = LW'(thr);
    mem_cmd_ready = (cyc % 4) != 3;
    out_ready     = (rmode == 0) ? 1'b1 : ((cyc % rmode) != 0);
    mem_rdata_valid = (qhead != qtail) && (cyc >= qtime[qhead % 64]);
    mem_rdata     = word_at(qaddr[qhead % 64]);
    #1;
    fire = mem_cmd_valid && mem_cmd_ready;
    take = mem_rdata_valid && mem_rdata_ready;
    pop  = out_valid && out_ready;
    // R7
    chk(mem_rdata_ready == (issued != returned), "R7", int'(mem_rdata_ready), int'(issued != returned));
    // R4
    if (fire || ctl_rd_strobe) chk(fire == ctl_rd_strobe, "R4", int'(ctl_rd_strobe), int'(fire));
    if (ctl_rd_strobe) begin
      strobes++;
      // R3
      chk(level > thr, "R3", level, thr + 1);
    end
    if (hold_pend) begin
      // R5
      chk(out_valid && out_data == held, "R5", int'(out_data), int'(held));
    end
    hold_pend = out_valid && !out_ready;
    held = out_data;
    if (fire) begin
      // R2
      chk(int'(mem_cmd_addr) == BASE + ridx && !mem_cmd_we, "R2", int'(mem_cmd_addr), BASE + ridx);
      t = cyc + 1 + (issued % 3);
      if (qhead != qtail && qtime[(qtail + 63) % 64] > t) t = qtime[(qtail + 63) % 64];
      qaddr[qtail % 64] = int'(mem_cmd_addr);
      qtime[qtail % 64] = t;
      qtail++;
      ridx = (ridx + 1) % DEPTH;
      issued++;
    end
    if (take) begin
      qhead++;
      returned++;
    end
    if (pop) begin
      // R8
      chk(out_data == word_at(BASE + popped % DEPTH), "R8", int'(out_data), int'(word_at(BASE + popped % DEPTH)));
      popped++;
    end
    // R6
    chk(issued - popped <= MAX_OUT, "R6", issued - popped, MAX_OUT);
    level = level + int'(wr) - int'(ctl_rd_strobe);
    if (wr) written++;
    cyc++;
  endtask

  task automatic run(input int thr_v, input int rm, input int n);
    int guard;
    thr = thr_v; rmode = rm;
    level = 0; ridx = 0; cyc = 0; qhead = 0; qtail = 0; written = 0;
    issued = 0; returned = 0; popped = 0; strobes = 0; hold_pend = 0;
    rst_n = 0;
    repeat (3) step(0);
    rst_n = 1;
    step(0);
    // R1
    chk(!out_valid && !mem_cmd_valid && !ctl_rd_strobe && !mem_rdata_ready, "R1",
        int'({out_valid, mem_cmd_valid, ctl_rd_strobe, mem_rdata_ready}), 0);
    repeat (thr_v) step(1);
    repeat (20) step(0);
    // R3
    chk(strobes == 0 && popped == 0, "R3", strobes + popped, 0);
    guard = 0;
    while (popped < n && guard < 3000) begin
      step(written < n + thr_v);
      guard++;
    end
    chk(guard < 3000, "watchdog", guard, 3000);
    repeat (15) step(0);
    // R3
    chk(level == thr_v, "R3", level, thr_v);
    // R4
    chk(strobes == n && issued == n, "R4", strobes, n);
    // R8
    chk(popped == n, "R8", popped, n);
  endtask

  initial begin
    run(0, 0, 30);
    run(3, 3, 30);
    run(8, 2, 40);
    run(1, 5, 25);
    run(5, 0, 26);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule